// File: doc/BRIEF.md
# Shared-Prescaler Tick Generator for Countdown Timers

This block turns one fixed input clock into a separate count-enable strobe for each of five countdown timer channels. Two 8-bit prescalers are shared among the channels. Channels 0 and 1 follow the first prescaler, and channels 2, 3 and 4 follow the second. Each channel then passes its prescaler's strobes through its own power-of-two divider. A channel's tick rate is therefore the clock rate divided by (prescale + 1) and then by 2^N.

Two 32-bit configuration words control the rates, and both can be read back. A single write port updates either word while the block is running. A write to the prescale word restarts both prescalers and all divider counts. A write to the divider word restarts only the channels whose field value changes. Each tick output is high for one clock cycle, and the downstream countdown counter uses it as its count enable.

Top module: `pwm_tick_gen`

## Requirements
- R1: Prescaler g (g = 0 or 1) takes its value P from bits [8g+7:8g] of the prescale word. It strobes once every P+1 clock cycles. P = 0 gives a strobe in every cycle.
- R2: Channels 0 and 1 count strobes from prescaler 0, and channels 2 to 4 count strobes from prescaler 1. A channel ticks only in a cycle in which its prescaler strobes.
- R3: Channel n takes the field N from bits [4n+3:4n] of the divider word. It ticks on every 2^N-th strobe of its prescaler, so its tick period is (P+1)·2^N cycles.
- R4: A divider field value from 5 to 15 divides by 16, the same as a value of 4.
- R5: After a synchronous active-low reset, the prescale word reads 0x0000_0101 and the divider word reads 0x0000_0000. The first tick of every channel then comes in the second cycle after reset is released, and further ticks follow every second cycle.
- R6: A write with cfg_wr_sel = 0 replaces the prescale word. Both prescalers and all five divider counts restart at that clock edge. Channel n then first ticks in cycle (P+1)·2^N − 1, counting the cycle right after the write edge as cycle 0.
- R7: A write with cfg_wr_sel = 1 replaces the divider word. Each channel whose 4-bit field changes clears its divider count at that edge. A prescaler strobe in the cycle of that write is not counted for that channel. Channels whose field does not change keep their phase.
- R8: Both words store all 32 written bits and return them on their readback ports from the cycle after the write edge. Without a write, neither word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fixed input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for one configuration word |
| cfg_wr_sel | input | 1 | Target word: 0 = prescale word, 1 = divider word |
| cfg_wr_data | input | 32 | Value to write |
| pre_word_o | output | 32 | Readback of the prescale word |
| div_word_o | output | 32 | Readback of the divider word |
| tick_o | output | 5 | One-cycle count-enable strobe per channel |

## Verification
A divider-word write can land in the same cycle as a prescaler strobe. For a channel whose field changes, the clear must win and that strobe must be dropped. For the other channels on the same prescaler, the strobe must still be counted. The bench provokes this case with a sweep of divider writes at spacings that step through a whole prescaler period, so some writes fall on strobe cycles and some fall between them. A reference model built from the rate rules predicts every channel's tick in every cycle, and a monitor compares that prediction with tick_o at the falling edge.

// File: rtl/ptg_pkg.sv
// Package: shared helpers for the tick generator.
// Assumes: channel indices below the split point use prescaler 0.
package ptg_pkg;

    // Select which prescaler feeds a channel
    function automatic int unsigned pre_of_channel(input int unsigned ch,
                                                   input int unsigned split);
        return (ch < split) ? 0 : 1;
    endfunction

endpackage

// File: rtl/ptg_cfg_regs.sv
// Module: configuration word storage and change detection.
// Holds the prescale word and the divider word, both fully writable.
// Flags a prescale restart on a prescale-word write, and flags each
// channel whose divider field a divider-word write changes.
// Assumes: a single write port; the readback is the stored word.
module ptg_cfg_regs #(
    parameter int unsigned      WORD_W  = 32,
    parameter int unsigned      NUM_CH  = 5,
    parameter int unsigned      SEL_W   = 4,
    parameter logic [WORD_W-1:0] PRE_RST = 32'h0000_0101,
    parameter logic [WORD_W-1:0] DIV_RST = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] pre_word,
    output logic [WORD_W-1:0] div_word,
    output logic              pre_load,
    output logic [NUM_CH-1:0] sel_clr
);

    // Store the addressed word on a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_word <= PRE_RST;
            div_word <= DIV_RST;
        end else if (wr_en) begin
            if (wr_sel) div_word <= wr_data;
            else        pre_word <= wr_data;
        end
    end

    // Prescale-word write restarts every prescaler and divider
    always_comb pre_load = wr_en && !wr_sel;

    // Per channel: a divider-word write that changes the field clears it
    for (genvar c = 0; c < NUM_CH; c++) begin : g_clr
        always_comb sel_clr[c] = wr_en && wr_sel &&
            (wr_data[c*SEL_W +: SEL_W] != div_word[c*SEL_W +: SEL_W]);
    end

    p_reset_words_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pre_word == PRE_RST && div_word == DIV_RST));

    p_hold_without_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(pre_word) && $stable(div_word)));

endmodule

// File: rtl/ptg_prescaler.sv
// Module: one shared prescaler.
// A free-running down counter. It strobes in every cycle in which it
// holds zero, then reloads from the current prescale value.
// Assumes: load takes priority and restarts the count from load_val.
module ptg_prescaler #(
    parameter int unsigned       PRE_W   = 8,
    parameter logic [PRE_W-1:0]  RST_CNT = 8'd1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] period_i,
    input  logic             load_i,
    input  logic [PRE_W-1:0] load_val,
    output logic             stb_o
);

    logic [PRE_W-1:0] cnt;

    // Count down, reload at zero, restart on load
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= RST_CNT;
        else if (load_i)     cnt <= load_val;
        else if (cnt == '0)  cnt <= period_i;
        else                 cnt <= cnt - 1'b1;
    end

    // Strobe while the counter sits at zero
    always_comb stb_o = (cnt == '0);

    p_gap_after_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_o && !load_i && period_i != '0) |=> !stb_o);

    p_restart_delays_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && load_val != '0) |=> !stb_o);

endmodule

// File: rtl/ptg_divider.sv
// Module: per-channel power-of-two divider.
// Counts prescaler strobes and ticks on every 2^N-th strobe. Select values
// above MAX_SEL saturate to MAX_SEL.
// Assumes: clr has priority over a strobe in the same cycle.
module ptg_divider #(
    parameter int unsigned SEL_W   = 4,
    parameter int unsigned MAX_SEL = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb_i,
    input  logic             clr_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);

    localparam int unsigned EFF_W = $clog2(MAX_SEL + 1);

    logic [MAX_SEL-1:0] dcnt;
    logic [EFF_W-1:0]   eff_sel;
    logic [MAX_SEL-1:0] mask;

    // Saturate the divider select
    always_comb eff_sel = (sel_i > SEL_W'(MAX_SEL)) ? EFF_W'(MAX_SEL) : EFF_W'(sel_i);

    // Low-bit mask of width eff_sel
    always_comb mask = ~({MAX_SEL{1'b1}} << eff_sel);

    // Count strobes; clear on a restart request
    always_ff @(posedge clk) begin
        if (!rst_n)      dcnt <= '0;
        else if (clr_i)  dcnt <= '0;
        else if (stb_i)  dcnt <= dcnt + 1'b1;
    end

    // Tick on the strobe that completes a 2^N group
    always_comb tick_o = stb_i && ((dcnt & mask) == mask);

    p_tick_on_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> stb_i);

    p_clear_restarts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!tick_o || eff_sel == '0));

endmodule

// File: rtl/pwm_tick_gen.sv
// Module: top of the tick generator.
// Two shared prescalers feed NUM_CH channel dividers. Channels below
// SPLIT_CH use prescaler 0, and the rest use prescaler 1.
// Assumes: WORD_W holds NUM_CH select fields and two prescale fields.
module pwm_tick_gen #(
    parameter int unsigned       NUM_CH   = 5,
    parameter int unsigned       SPLIT_CH = 2,
    parameter int unsigned       PRE_W    = 8,
    parameter int unsigned       SEL_W    = 4,
    parameter int unsigned       MAX_SEL  = 4,
    parameter int unsigned       WORD_W   = 32,
    parameter logic [WORD_W-1:0] PRE_RST  = 32'h0000_0101,
    parameter logic [WORD_W-1:0] DIV_RST  = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic              cfg_wr_sel,
    input  logic [31:0]       cfg_wr_data,
    output logic [31:0]       pre_word_o,
    output logic [31:0]       div_word_o,
    output logic [NUM_CH-1:0] tick_o
);
    import ptg_pkg::*;

    localparam int unsigned NUM_PRE = 2;

    logic [WORD_W-1:0]  pre_word;
    logic [WORD_W-1:0]  div_word;
    logic               pre_load;
    logic [NUM_CH-1:0]  sel_clr;
    logic [NUM_PRE-1:0] pre_stb;

    ptg_cfg_regs #(
        .WORD_W (WORD_W),
        .NUM_CH (NUM_CH),
        .SEL_W  (SEL_W),
        .PRE_RST(PRE_RST),
        .DIV_RST(DIV_RST)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_sel  (cfg_wr_sel),
        .wr_data (cfg_wr_data),
        .pre_word(pre_word),
        .div_word(div_word),
        .pre_load(pre_load),
        .sel_clr (sel_clr)
    );

    // Readback ports mirror the stored words
    always_comb begin
        pre_word_o = pre_word;
        div_word_o = div_word;
    end

    for (genvar g = 0; g < NUM_PRE; g++) begin : g_pre
        ptg_prescaler #(
            .PRE_W  (PRE_W),
            .RST_CNT(PRE_RST[g*PRE_W +: PRE_W])
        ) u_pre (
            .clk     (clk),
            .rst_n   (rst_n),
            .period_i(pre_word[g*PRE_W +: PRE_W]),
            .load_i  (pre_load),
            .load_val(cfg_wr_data[g*PRE_W +: PRE_W]),
            .stb_o   (pre_stb[g])
        );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_div
        localparam int unsigned SRC = pre_of_channel(c, SPLIT_CH);
        ptg_divider #(
            .SEL_W  (SEL_W),
            .MAX_SEL(MAX_SEL)
        ) u_div (
            .clk   (clk),
            .rst_n (rst_n),
            .stb_i (pre_stb[SRC]),
            .clr_i (pre_load || sel_clr[c]),
            .sel_i (div_word[c*SEL_W +: SEL_W]),
            .tick_o(tick_o[c])
        );
    end

    p_group_ticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o[0] && !pre_load) |-> pre_stb[0]);

endmodule

// File: tb/pwm_tick_gen_bench.sv
`timescale 1ns/1ps
module pwm_tick_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_wr_sel = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic [31:0] pre_word_o;
    logic [31:0] div_word_o;
    logic [4:0]  tick_o;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 1'b0;
    string cur_req  = "R5";

    // Reference model state
    logic [31:0] m_pre = 32'h0000_0101;
    logic [31:0] m_div = 32'h0;
    int          pa [2];
    int          nst [5];
    logic [5:0]  exp_q [$];

    always #10 clk = ~clk;

    pwm_tick_gen u_pwm_tick_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr_en  (cfg_wr_en),
        .cfg_wr_sel (cfg_wr_sel),
        .cfg_wr_data(cfg_wr_data),
        .pre_word_o (pre_word_o),
        .div_word_o (div_word_o),
        .tick_o     (tick_o)
    );

    function automatic int grp(input int c);
        return (c < 2) ? 0 : 1;
    endfunction

    function automatic int pval(input int g);
        return int'(m_pre[8*g +: 8]);
    endfunction

    function automatic int nval(input int c);
        int n;
        n = int'(m_div[4*c +: 4]);
        return (n > 4) ? 4 : n;
    endfunction

    // Model: advance one cycle per edge, push the prediction for the new cycle
    always @(posedge clk) begin
        bit  stb [2];
        logic [4:0] e;
        if (!rst_n) begin
            m_pre = 32'h0000_0101;
            m_div = 32'h0;
            for (int g = 0; g < 2; g++) pa[g] = 0;
            for (int c = 0; c < 5; c++) nst[c] = 0;
        end else begin
            for (int g = 0; g < 2; g++) stb[g] = ((pa[g] + 1) % (pval(g) + 1)) == 0;
            for (int c = 0; c < 5; c++) if (stb[grp(c)]) nst[c]++;
            for (int g = 0; g < 2; g++) pa[g]++;
            if (cfg_wr_en && !cfg_wr_sel) begin
                m_pre = cfg_wr_data;
                for (int g = 0; g < 2; g++) pa[g] = 0;
                for (int c = 0; c < 5; c++) nst[c] = 0;
            end else if (cfg_wr_en && cfg_wr_sel) begin
                for (int c = 0; c < 5; c++)
                    if (cfg_wr_data[4*c +: 4] != m_div[4*c +: 4]) nst[c] = 0;
                m_div = cfg_wr_data;
            end
        end
        for (int g = 0; g < 2; g++) stb[g] = ((pa[g] + 1) % (pval(g) + 1)) == 0;
        for (int c = 0; c < 5; c++)
            e[c] = stb[grp(c)] && (((nst[c] + 1) % (1 << nval(c))) == 0);
        exp_q.push_back({rst_n, e});
    end

    // Monitor: pop one prediction per cycle and compare away from the edge
    always @(negedge clk) begin
        logic [5:0] item;
        if (exp_q.size() > 0 && !done) begin
            item = exp_q.pop_front();
            if (item[5]) begin
                n_checks++;
                if (tick_o !== item[4:0]) begin
                    n_fails++;
                    $display("FAIL %s tick_o actual %b expected %b at %0t",
                             cur_req, tick_o, item[4:0], $time);
                end
            end
        end
    end

    task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fails++;
            $display("FAIL %s readback actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic wr(input bit sel, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_wr_data = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R5: reset values and default tick pattern
        chk32("R5", pre_word_o, 32'h0000_0101);
        chk32("R5", div_word_o, 32'h0);
        n_checks++;
        if (tick_o !== 5'b0) begin
            n_fails++;
            $display("FAIL R5 tick in reset actual %b expected 00000", tick_o);
        end
        rst_n = 1'b1;
        cur_req = "R5";
        idle(40);
        // R1/R2/R6: new prescale values restart everything
        cur_req = "R6";
        wr(1'b0, 32'h0000_0302);
        chk32("R6", pre_word_o, 32'h0000_0302);
        cur_req = "R1";
        idle(100);
        // R3/R4: per-channel dividers, channel 4 saturates
        cur_req = "R3";
        wr(1'b1, 32'h0007_3021);
        chk32("R3", div_word_o, 32'h0007_3021);
        cur_req = "R4";
        idle(300);
        // R7: changing only channel 1 at stepped spacings
        cur_req = "R7";
        for (int k = 0; k < 10; k++) begin
            wr(1'b1, (k % 2 == 0) ? 32'h0007_3011 : 32'h0007_3021);
            idle(k + 1);
        end
        idle(200);
        // R7: rewriting the same value leaves phases alone
        wr(1'b1, 32'h0007_3021);
        idle(80);
        // R1: zero prescale strobes every cycle
        cur_req = "R1";
        wr(1'b0, 32'h0000_0000);
        idle(20);
        wr(1'b1, 32'h0000_0000);
        cur_req = "R2";
        idle(20);
        // R4: field 15 behaves as divide by 16
        cur_req = "R4";
        wr(1'b1, 32'h0004_000F);
        idle(80);
        // R8: full 32-bit storage and hold
        cur_req = "R8";
        wr(1'b1, 32'hABC4_100F);
        wr(1'b0, 32'hFFFF_0100);
        idle(10);
        chk32("R8", div_word_o, 32'hABC4_100F);
        chk32("R8", pre_word_o, 32'hFFFF_0100);
        idle(100);
        chk32("R8", pre_word_o, 32'hFFFF_0100);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fails++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule